// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns a stream of stereo sample pairs into a single serial data line. A frame clock marks each frame and a bit clock times each bit. Each frame is 64 bit-clock periods long. Every sample is held internally as a 24-bit signed value. The selected output word length either truncates it to 16 or 20 bits, sends it whole as 24 bits, or pads it with eight zero bits to make 32. Bits go out MSB first.

Two frame layouts share one slot-addressed shifter:

- **Right-justified:** each channel's LSB sits in the last slot of that channel's half-frame.
- **DSP-style:** a one-slot frame pulse marks the frame. The left word starts in slot 0 or slot 1, and the right word follows the left word with no gap.

The block has two clocking modes:

- **Master:** the block divides its system clock to produce both clocks.
- **Slave:** the block synchronizes an external bit clock and frame clock, and drives data off the external falling bit-clock edges.

Upstream logic hands over sample pairs through a valid/ready pair. A one-deep holding register accepts a pair, and the pair is latched into the shifter at the start of a frame. All configuration inputs are captured only while the block is disabled.

Top module: `aud_ser_tx`

## Requirements
- R1: While `rst_ni` is low, and from the first clock edge at which `en_i` is low, `sdata_o`, `bclk_o` and `lrclk_o` are low.
- R2: In master mode `bclk_o` stays in each level for `div_i`+1 clock cycles. A frame is 64 bit-clock periods, and slot k begins on a falling `bclk_o` edge. `lrclk_o` is high in slots 0..31 in right-justified mode, and only in slot 0 in DSP mode.
- R3: In master mode `sdata_o` and `lrclk_o` change only together with a falling `bclk_o` edge, so they are stable at every rising edge.
- R4: `wlen_i` selects the word length n: 0 gives 16, 1 gives 20, 2 gives 24, 3 gives 32. For n < 24 the low 24-n bits of the sample are dropped. For n = 32 eight zero bits follow the sample's LSB.
- R5: Right-justified mode (`dsp_i`=0): the left word occupies slots 32-n..31 and the right word occupies slots 64-n..63, each MSB first. All other slots are low.
- R6: DSP mode (`dsp_i`=1): with `msb_late_i`=0 the left MSB is in slot 0, the first rising edge after the frame clock goes high; with `msb_late_i`=1 it is in slot 1. The right MSB immediately follows the left LSB. Other slots are low. For n = 32 with the late MSB, the right word's final bit falls outside the frame; that bit is always a pad zero and is not sent.
- R7: `smp_ready_o` is high exactly when the holding register is empty. A pair is accepted on `smp_valid_i` and `smp_ready_o`. A held pair is moved into the shifter at the start of the next frame. A frame that starts with nothing held sends all zeros.
- R8: `master_i`, `dsp_i`, `msb_late_i`, `wlen_i` and `div_i` are captured only while `en_i` is low. Changes while running have no effect on the frames sent.
- R9: In slave mode (`master_i`=0) `bclk_o` and `lrclk_o` stay low. A frame starts at the falling `bclk_i` edge where `lrclk_i` has newly gone high. `sdata_o` changes within 3 clock cycles of each falling `bclk_i` edge and follows the slot layout of R5/R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low means standby and configuration capture |
| master_i | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| dsp_i | input | 1 | 1 = DSP-style framing, 0 = right-justified |
| msb_late_i | input | 1 | DSP mode: left MSB in slot 1 instead of slot 0 |
| wlen_i | input | 2 | Word length code (16/20/24/32) |
| div_i | input | DIV_W | Bit-clock half period in clock cycles, minus one |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Holding register empty |
| smp_l_i | input | SMP_W | Left sample, two's complement |
| smp_r_i | input | SMP_W | Right sample, two's complement |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrclk_o | output | 1 | Generated frame clock (master) |
| sdata_o | output | 1 | Serial data |

## Verification
Two events fall on the same clock edge at every frame start. The held pair is released into the shifter, and the MSB of that same pair must already be driven in slot 0. The bench provokes this by pushing the next pair while the previous frame is still running. It then reads frame slot 0 back at the rising bit-clock edge in DSP mode with the early MSB, where a one-edge lag would show up as a shifted or zero word. A second overlap is the start of a frame with nothing held. This is judged by requiring the following frame to be entirely zero, while the preceding frame still carries its full word.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int FRAME_SLOTS = 64;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int CH_W        = 32;

  typedef enum logic [1:0] {WL16 = 2'd0, WL20 = 2'd1, WL24 = 2'd2, WL32 = 2'd3} wlen_e;

  typedef struct packed {
    logic  master;
    logic  dsp;
    logic  late;
    wlen_e wlen;
  } cfg_t;

  function automatic logic [6:0] wlen_bits(wlen_e w);
    case (w)
      WL16:    return 7'd16;
      WL20:    return 7'd20;
      WL24:    return 7'd24;
      default: return 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bclk_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_i);
  assign fall_o = wrap && bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/aud_tx_slvsync.sv
module aud_tx_slvsync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic fall_o,
  output logic lr_o
);
  logic [2:0] bclk_sq;
  logic [1:0] lr_sq;

  // both paths share depth so lr_o is aligned with fall_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_sq <= '0;
      lr_sq   <= '0;
    end else begin
      bclk_sq <= {bclk_sq[1:0], bclk_i};
      lr_sq   <= {lr_sq[0], lrclk_i};
    end
  end

  assign fall_o = bclk_sq[2] && !bclk_sq[1];
  assign lr_o   = lr_sq[1];
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  cfg_t             cfg_i,
  input  logic             fall_i,
  input  logic             ext_lr_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  output logic             sdata_o,
  output logic             lrclk_o
);
  localparam int PAD = CH_W - SMP_W;

  logic [SLOT_W-1:0] slot_q, nxt_slot;
  logic              lr_prev_q, locked_q, full_q;
  logic [SMP_W-1:0]  hold_l_q, hold_r_q, act_l_q, act_r_q;
  logic [SMP_W-1:0]  cur_l, cur_r;
  logic              sdata_q, lr_q;
  logic              start, emit, bit_d, lr_d, accept;
  logic [6:0]        n7, off, pos, idx, e1, e2, dly;
  logic [CH_W-1:0]   msk, wl, wr;

  assign smp_ready_o = !full_q;
  assign accept      = smp_valid_i && !full_q;
  assign sdata_o     = sdata_q;
  assign lrclk_o     = lr_q;

  always_comb begin
    nxt_slot = slot_q + 1'b1;
    if (cfg_i.master) begin
      start = (nxt_slot == '0);
    end else begin
      start = ext_lr_i && !lr_prev_q;
      if (start) nxt_slot = '0;
    end
    emit  = cfg_i.master || locked_q || start;
    cur_l = start ? (full_q ? hold_l_q : '0) : act_l_q;
    cur_r = start ? (full_q ? hold_r_q : '0) : act_r_q;
  end

  // slot-addressed bit pick shared by both framings
  always_comb begin
    n7    = wlen_bits(cfg_i.wlen);
    msk   = ~({CH_W{1'b1}} >> n7);
    wl    = {cur_l, {PAD{1'b0}}} & msk;
    wr    = {cur_r, {PAD{1'b0}}} & msk;
    off   = 7'd32 - n7;
    dly   = {6'd0, cfg_i.late};
    e1    = dly + n7;
    e2    = e1 + n7;
    pos   = '0;
    idx   = '0;
    bit_d = 1'b0;
    if (!cfg_i.dsp) begin
      pos = {2'b00, nxt_slot[4:0]};
      if (pos >= off) begin
        idx   = pos - off;
        bit_d = nxt_slot[5] ? wr[~idx[4:0]] : wl[~idx[4:0]];
      end
      lr_d = !nxt_slot[5];
    end else begin
      pos = {1'b0, nxt_slot};
      if (pos >= dly && pos < e1) begin
        idx   = pos - dly;
        bit_d = wl[~idx[4:0]];
      end else if (pos >= e1 && pos < e2) begin
        idx   = pos - e1;
        bit_d = wr[~idx[4:0]];
      end
      lr_d = (nxt_slot == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q    <= '1;
      lr_prev_q <= 1'b1;
      locked_q  <= 1'b0;
      act_l_q   <= '0;
      act_r_q   <= '0;
      sdata_q   <= 1'b0;
      lr_q      <= 1'b0;
    end else if (!run_i) begin
      slot_q    <= '1;
      lr_prev_q <= 1'b1;
      locked_q  <= 1'b0;
      sdata_q   <= 1'b0;
      lr_q      <= 1'b0;
    end else if (fall_i) begin
      slot_q    <= nxt_slot;
      lr_prev_q <= ext_lr_i;
      if (start) begin
        locked_q <= 1'b1;
        act_l_q  <= cur_l;
        act_r_q  <= cur_r;
      end
      sdata_q <= emit && bit_d;
      lr_q    <= cfg_i.master && lr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (accept) begin
      full_q   <= 1'b1;
      hold_l_q <= smp_l_i;
      hold_r_q <= smp_r_i;
    end else if (run_i && fall_i && start) begin
      full_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             master_i,
  input  logic             dsp_i,
  input  logic             msb_late_i,
  input  logic [1:0]       wlen_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             sdata_o
);
  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  logic             master_q;
  logic             m_fall, s_fall, s_lr, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{master: 1'b1, dsp: 1'b0, late: 1'b0, wlen: WL24};
      div_q <= '0;
    end else if (!en_i) begin
      cfg_q <= '{master: master_i, dsp: dsp_i, late: msb_late_i, wlen: wlen_e'(wlen_i)};
      div_q <= div_i;
    end
  end

  assign master_q = cfg_q.master;
  assign fall     = master_q ? m_fall : s_fall;

  aud_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i && master_q),
    .div_i  (div_q),
    .bclk_o (bclk_o),
    .fall_o (m_fall)
  );

  aud_tx_slvsync u_slvsync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_i),
    .lrclk_i (lrclk_i),
    .fall_o  (s_fall),
    .lr_o    (s_lr)
  );

  aud_tx_framer #(.SMP_W(SMP_W)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (en_i),
    .cfg_i       (cfg_q),
    .fall_i      (fall),
    .ext_lr_i    (s_lr),
    .smp_valid_i (smp_valid_i),
    .smp_ready_o (smp_ready_o),
    .smp_l_i     (smp_l_i),
    .smp_r_i     (smp_r_i),
    .sdata_o     (sdata_o),
    .lrclk_o     (lrclk_o)
  );
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_q,
  input logic smp_valid_i,
  input logic smp_ready_o,
  input logic bclk_o,
  input logic lrclk_o,
  input logic sdata_o
);
  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sdata_o && !bclk_o && !lrclk_o));

  // R3
  data_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_q && $past(en_i) && !$stable(sdata_o)) |-> $fell(bclk_o));

  // R2
  frame_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_q && $past(en_i) && !$stable(lrclk_o)) |-> $fell(bclk_o));

  // R9
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_q |-> (!bclk_o && !lrclk_o));

  // R7
  hold_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(master_q));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .master_q    (master_q),
  .smp_valid_i (smp_valid_i),
  .smp_ready_o (smp_ready_o),
  .bclk_o      (bclk_o),
  .lrclk_o     (lrclk_o),
  .sdata_o     (sdata_o)
);

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;
  logic        clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic        master_i = 1'b1, dsp_i = 1'b0, msb_late_i = 1'b0;
  logic [1:0]  wlen_i = 2'd2;
  logic [7:0]  div_i = 8'd0;
  logic        smp_valid_i = 1'b0, smp_ready_o;
  logic [23:0] smp_l_i = '0, smp_r_i = '0;
  logic        bclk_i = 1'b1, lrclk_i = 1'b0;
  logic        bclk_o, lrclk_o, sdata_o;
  int          checks = 0, errors = 0, cyc = 0;

  always #5 clk_i = ~clk_i;

  aud_ser_tx u0 (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [0:63] exp_frame(input logic dsp, input logic late, input logic [1:0] wl,
                                            input logic [23:0] l, input logic [23:0] r);
    int n;
    logic [0:31] lw, rw;
    logic [0:63] f;
    n  = (wl == 0) ? 16 : (wl == 1) ? 20 : (wl == 2) ? 24 : 32;
    lw = '0; rw = '0; f = '0;
    for (int i = 0; i < n; i++) begin
      lw[i] = (i < 24) ? l[23-i] : 1'b0;
      rw[i] = (i < 24) ? r[23-i] : 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      if (!dsp) begin
        f[32-n+i] = lw[i];
        f[64-n+i] = rw[i];
      end else begin
        if (late + i < 64)     f[late+i]     = lw[i];
        if (late + n + i < 64) f[late+n+i]   = rw[i];
      end
    end
    return f;
  endfunction

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk_i);
    while (!smp_ready_o) @(negedge clk_i);
    smp_l_i = l; smp_r_i = r; smp_valid_i = 1'b1;
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    chk("R7 ready low after accept", {63'd0, smp_ready_o}, 64'd0);
  endtask

  // records slot data and frame clock at each rising bclk_o, starting at a frame-clock rise
  task automatic capture(output logic [0:63] dat, output logic [0:63] lr, output int viol);
    int   k = -1;
    logic bp = bclk_o, lp = 1'b1, sp = sdata_o;
    viol = 0; dat = '0; lr = '0;
    while (k < 64) begin
      @(negedge clk_i);
      if (bclk_o && bp && sdata_o != sp) viol++;
      if (bclk_o && !bp) begin
        if (k < 0 && lrclk_o && !lp) k = 0;
        if (k >= 0) begin
          dat[k] = sdata_o; lr[k] = lrclk_o; k++;
        end
        lp = lrclk_o;
      end
      bp = bclk_o; sp = sdata_o;
    end
  endtask

  task automatic configure(input logic m, input logic d, input logic late, input logic [1:0] wl,
                           input logic [7:0] dv);
    @(negedge clk_i);
    en_i = 1'b0; master_i = m; dsp_i = d; msb_late_i = late; wlen_i = wl; div_i = dv;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_master(input string tag, input logic d, input logic late, input logic [1:0] wl,
                            input logic [23:0] al, input logic [23:0] ar,
                            input logic [23:0] bl, input logic [23:0] br, input logic alter);
    logic [0:63] dat, lr, exp_lr;
    int viol;
    configure(1'b1, d, late, wl, 8'd0);
    push(al, ar);
    en_i = 1'b1;
    push(bl, br);
    if (alter) begin
      wlen_i = ~wl; dsp_i = ~d; msb_late_i = ~late; div_i = 8'd5;
    end
    capture(dat, lr, viol);
    chk({tag, " data"}, dat, exp_frame(d, late, wl, bl, br));
    for (int k = 0; k < 64; k++) exp_lr[k] = d ? (k == 0) : (k < 32);
    chk("R2 frame clock shape", lr, exp_lr);
    chk("R3 data stable while bclk high", 64'(viol), 64'd0);
    capture(dat, lr, viol);
    chk("R7 underrun frame zero", dat, 64'd0);
    @(negedge clk_i); en_i = 1'b0;
    @(negedge clk_i);
    chk("R1 standby outputs low", {61'd0, sdata_o, bclk_o, lrclk_o}, 64'd0);
  endtask

  task automatic test_reset;
    chk("R1 reset outputs low", {61'd0, sdata_o, bclk_o, lrclk_o}, 64'd0);
    chk("R7 ready after reset", {63'd0, smp_ready_o}, 64'd1);
  endtask

  task automatic test_period;
    int t0, t1;
    configure(1'b1, 1'b0, 1'b0, 2'd2, 8'd2);
    en_i = 1'b1;
    @(posedge bclk_o); t0 = cyc;
    @(posedge bclk_o); t1 = cyc;
    chk("R2 bclk period", 64'(t1 - t0), 64'd6);
    @(negedge clk_i); en_i = 1'b0;
  endtask

  task automatic test_slave;
    logic [0:63] dat, exp;
    logic        qv = 1'b0;
    configure(1'b0, 1'b0, 1'b0, 2'd2, 8'd0);
    push(24'h5A3C96, 24'hE1F00F);
    en_i = 1'b1;
    for (int s = -4; s < 64; s++) begin
      bclk_i = 1'b0; lrclk_i = (s >= 0 && s < 32);
      repeat (4) @(negedge clk_i);
      bclk_i = 1'b1;
      if (s >= 0) dat[s] = sdata_o;
      qv = qv | bclk_o | lrclk_o;
      repeat (4) @(negedge clk_i);
    end
    exp = exp_frame(1'b0, 1'b0, 2'd2, 24'h5A3C96, 24'hE1F00F);
    chk("R9 slave frame data", dat, exp);
    chk("R9 slave clocks quiet", {63'd0, qv}, 64'd0);
    @(negedge clk_i); en_i = 1'b0;
    @(negedge clk_i);
    chk("R1 slave standby low", {63'd0, sdata_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_master("R5 R4 rj 24",      1'b0, 1'b0, 2'd2, 24'h123456, 24'h654321, 24'hA5C3F1, 24'h3C5A97, 1'b0);
    run_master("R5 R4 rj 16 trunc", 1'b0, 1'b0, 2'd0, 24'h0F0F0F, 24'hF0F0F0, 24'h9ABCDE, 24'h7654FF, 1'b0);
    run_master("R5 R4 rj 20 trunc", 1'b0, 1'b0, 2'd1, 24'h111111, 24'h222222, 24'hC0FFEE, 24'h8BADF3, 1'b0);
    run_master("R5 R4 rj 32 pad",   1'b0, 1'b0, 2'd3, 24'h333333, 24'h444444, 24'hFFFFFF, 24'h80000F, 1'b0);
    run_master("R6 dsp early 24",   1'b1, 1'b0, 2'd2, 24'h555555, 24'h666666, 24'hB16B00, 24'h4D2E1F, 1'b0);
    run_master("R6 dsp late 16",    1'b1, 1'b1, 2'd0, 24'h777777, 24'h888888, 24'hE7A9C1, 24'h1FFFFF, 1'b0);
    run_master("R6 dsp early 32",   1'b1, 1'b0, 2'd3, 24'h999999, 24'hAAAAAA, 24'hFFFFFF, 24'hFFFFFF, 1'b0);
    run_master("R6 dsp late 32",    1'b1, 1'b1, 2'd3, 24'hBBBBBB, 24'hCCCCCC, 24'hFFFFFF, 24'hFFFFFF, 1'b0);
    run_master("R8 cfg change ignored", 1'b0, 1'b0, 2'd2, 24'hDDDDDD, 24'hEEEEEE, 24'h2468AC, 24'hFDB975, 1'b1);
    test_period();
    test_slave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule